// File: doc/BRIEF.md
# Configuration-space read responder

Each peripheral on a shared 32-bit system bus carries this responder so that software can find and identify it. The peripheral holds an 8-bit virtual ID that can be set to any value. When a read cycle on the configuration space carries that virtual ID, the responder returns a small read-only descriptor. The descriptor is little-endian and holds the following:

- a four-character type code;
- the peripheral's fixed physical slot number;
- the virtual ID of the bus master it sits under;
- bit-inverted copies of the slot number and the master ID.

Two components that share a virtual ID both drive the bus at once. Their normal and inverted copies then no longer match, so software can detect the conflict.

The block can optionally carry two extra 32-bit extension codes. Without them, only the low three offset bits are decoded and the descriptor repeats every 8 bytes. Any read that the responder does not claim shows the all-ones open-bus value. Read data and the driving flag are registered and come out one clock after the read strobe.

Top module: `cfg_responder`

## Requirements
- R1: After synchronous reset, `drv` is 0 and `rdata` is 32'hFFFF_FFFF.
- R2: A read is claimed when all of these hold: `sel` and `rd` are high, `req_vid` equals `own_vid`, and `own_vid` is not 8'hFF. On the next clock edge the claimed data appears on `rdata` and `drv` goes to 1 at that same edge.
- R3: If `own_vid` is 8'hFF, the component never claims a read, even when `req_vid` is also 8'hFF.
- R4: Each of the following is ignored: a cycle with `rd` low (a write attempt), a `req_vid` mismatch, or `sel` low. After such a cycle, `drv` is 0 and `rdata` is all ones.
- R5: Descriptor offsets 0..3 hold `TYPE_ID` in little-endian order. Offset 0 is `TYPE_ID[7:0]`, so a word read at offset 0 returns `TYPE_ID`.
- R6: The remaining fixed descriptor bytes are:
  - offset 4: `PHYS_ID`;
  - offset 5: `master_vid` (8'hFF when the master is the root);
  - offset 6: `~PHYS_ID`;
  - offset 7: `~master_vid`.
- R7: The `size` input selects the read width:
  - 0 is a byte, returned in `rdata[7:0]` with bits 31:8 all ones;
  - 1 is a halfword, returned in `rdata[15:0]` with bits 31:16 all ones;
  - 2 and 3 are a full word.
- R8: Reads may start at any offset. Byte lane k carries the descriptor byte at (offset + k) modulo the window size. The window is 8 bytes, or 16 bytes with extensions.
- R9: With `EXT_EN`=0, only offset bits 2:0 are decoded, so offsets 8..15 and any higher address repeat offsets 0..7. With `EXT_EN`=1, offsets 8..11 hold `EXT_ID0` and offsets 12..15 hold `EXT_ID1`, both little-endian, and bits above 3 are ignored.
- R10: `rdata` is all ones whenever `drv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_vid | input | 8 | This component's settable virtual ID |
| master_vid | input | 8 | Virtual ID of the owning bus master |
| sel | input | 1 | Configuration-space cycle select |
| rd | input | 1 | Read strobe |
| req_vid | input | 8 | Virtual ID addressed by the cycle |
| addr | input | ADDR_W | Byte offset within the configuration space |
| size | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| drv | output | 1 | Component is driving `rdata` |
| rdata | output | 32 | Registered read data, all ones when idle |

## Verification
The bench runs two instances, one with extensions and one without, and checks each against a model of the descriptor computed from its own parameters.

It targets unaligned word reads that run off the end of the window. A design that did not wrap would return open-bus or out-of-range lanes where descriptor bytes belong.

It reads offsets 8 and above on the minimal variant and on high addresses. A design that failed to alias would show extension data or open bus there.

It also covers three further cases:
- A silent virtual ID of 8'hFF addressed as 8'hFF, which a naive compare would answer.
- A root master ID, which must give 8'hFF at offset 5 and 8'h00 at offset 7.
- Narrow reads, where an unmasked upper lane would leak descriptor bytes instead of ones.

// File: rtl/cfg_resp_pkg.sv
package cfg_resp_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } cfg_size_e;

  localparam logic [7:0]  VID_SILENT = 8'hFF;
  localparam logic [31:0] OPEN_BUS   = 32'hFFFF_FFFF;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_bytes = 3'd1;
      SZ_HALF: size_bytes = 3'd2;
      default: size_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/cfg_addr_match.sv
module cfg_addr_match
  import cfg_resp_pkg::*;
(
  input  logic       sel,
  input  logic       rd,
  input  logic [7:0] req_vid,
  input  logic [7:0] own_vid,
  output logic       hit
);
  logic id_eq;
  logic id_live;

  always_comb begin
    id_eq   = (req_vid == own_vid);
    id_live = (own_vid != VID_SILENT);
    hit     = sel && rd && id_eq && id_live;
  end
endmodule

// File: rtl/cfg_desc_table.sv
module cfg_desc_table #(
  parameter logic [31:0] TYPE_ID = 32'h0,
  parameter logic [7:0]  PHYS_ID = 8'h0,
  parameter bit          EXT_EN  = 1'b0,
  parameter logic [31:0] EXT_ID0 = 32'h0,
  parameter logic [31:0] EXT_ID1 = 32'h0,
  parameter int          WIN     = 8
) (
  input  logic [7:0]       master_vid,
  output logic [WIN*8-1:0] tbl
);
  localparam int BASE_BYTES = 8;

  always_comb begin
    tbl[31:0]  = TYPE_ID;
    tbl[39:32] = PHYS_ID;
    tbl[47:40] = master_vid;
    tbl[55:48] = ~PHYS_ID;
    tbl[63:56] = ~master_vid;
  end

  generate
    if (EXT_EN) begin : g_ext
      always_comb begin
        tbl[BASE_BYTES*8 +: 32]      = EXT_ID0;
        tbl[BASE_BYTES*8 + 32 +: 32] = EXT_ID1;
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_lane_sel.sv
module cfg_lane_sel
  import cfg_resp_pkg::*;
#(
  parameter int WIN    = 8,
  parameter int ADDR_W = 8
) (
  input  logic [WIN*8-1:0]  tbl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [31:0]       data
);
  localparam int IDX_W = $clog2(WIN);
  localparam int LANES = 4;

  logic [2:0] nbytes;
  assign nbytes = size_bytes(size);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDX_W-1:0] idx;
    always_comb begin
      idx = addr[IDX_W-1:0] + IDX_W'(k);
      if (3'(k) < nbytes) data[k*8 +: 8] = tbl[idx*8 +: 8];
      else                data[k*8 +: 8] = 8'hFF;
    end
  end
endmodule

// File: rtl/cfg_responder.sv
module cfg_responder
  import cfg_resp_pkg::*;
#(
  parameter logic [31:0] TYPE_ID = 32'h3072_6D54,
  parameter logic [7:0]  PHYS_ID = 8'h03,
  parameter bit          EXT_EN  = 1'b0,
  parameter logic [31:0] EXT_ID0 = 32'h0000_0000,
  parameter logic [31:0] EXT_ID1 = 32'h0000_0000,
  parameter int          ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        own_vid,
  input  logic [7:0]        master_vid,
  input  logic              sel,
  input  logic              rd,
  input  logic [7:0]        req_vid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              drv,
  output logic [31:0]       rdata
);
  localparam int WIN = EXT_EN ? 16 : 8;

  logic             hit;
  logic [WIN*8-1:0] tbl;
  logic [31:0]      lane_data;

  cfg_addr_match u_match (
    .sel     (sel),
    .rd      (rd),
    .req_vid (req_vid),
    .own_vid (own_vid),
    .hit     (hit)
  );

  cfg_desc_table #(
    .TYPE_ID (TYPE_ID),
    .PHYS_ID (PHYS_ID),
    .EXT_EN  (EXT_EN),
    .EXT_ID0 (EXT_ID0),
    .EXT_ID1 (EXT_ID1),
    .WIN     (WIN)
  ) u_table (
    .master_vid (master_vid),
    .tbl        (tbl)
  );

  cfg_lane_sel #(
    .WIN    (WIN),
    .ADDR_W (ADDR_W)
  ) u_lanes (
    .tbl  (tbl),
    .addr (addr),
    .size (size),
    .data (lane_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drv   <= 1'b0;
      rdata <= OPEN_BUS;
    end else begin
      drv   <= hit;
      rdata <= hit ? lane_data : OPEN_BUS;
    end
  end
endmodule

// File: rtl/cfg_responder_chk.sv
module cfg_responder_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [7:0]        own_vid,
  input logic              sel,
  input logic              rd,
  input logic [7:0]        req_vid,
  input logic [1:0]        size,
  input logic              drv,
  input logic [31:0]       rdata
);
  assert_claim_R2: assert property (@(posedge clk) disable iff (rst)
    (sel && rd && req_vid == own_vid && own_vid != 8'hFF) |=> drv);

  assert_silent_R3: assert property (@(posedge clk) disable iff (rst)
    (own_vid == 8'hFF) |=> !drv);

  assert_ignore_R4: assert property (@(posedge clk) disable iff (rst)
    !(sel && rd) |=> !drv);

  assert_byte_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (sel && rd && req_vid == own_vid && own_vid != 8'hFF && size == 2'd0)
      |=> rdata[31:8] == 24'hFF_FFFF);

  assert_open_bus_R10: assert property (@(posedge clk) disable iff (rst)
    !drv |-> rdata == 32'hFFFF_FFFF);
endmodule

bind cfg_responder cfg_responder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .own_vid (own_vid),
  .sel     (sel),
  .rd      (rd),
  .req_vid (req_vid),
  .size    (size),
  .drv     (drv),
  .rdata   (rdata)
);

// File: tb/tb_cfg_responder.sv
module tb_cfg_responder;
  localparam logic [31:0] T_TYPE  = 32'h3072_6D54;
  localparam logic [7:0]  T_PHYS  = 8'h03;
  localparam logic [31:0] T_TYPEX = 32'h3178_6E55;
  localparam logic [7:0]  T_PHYSX = 8'h9C;
  localparam logic [31:0] T_EXT0  = 32'hA1B2_C3D4;
  localparam logic [31:0] T_EXT1  = 32'h1526_3748;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] vid_a = 8'h21;
  logic [7:0] vid_b = 8'h35;
  logic [7:0] mvid = 8'h5A;
  logic       sel = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] req_vid = 8'h00;
  logic [7:0] addr = 8'h00;
  logic [1:0] size = 2'd0;
  logic       drv_a, drv_b;
  logic [31:0] rdata_a, rdata_b;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #2 clk = ~clk;

  cfg_responder #(.TYPE_ID(T_TYPE), .PHYS_ID(T_PHYS), .EXT_EN(1'b0)) dut (
    .clk(clk), .rst(rst), .own_vid(vid_a), .master_vid(mvid),
    .sel(sel), .rd(rd), .req_vid(req_vid), .addr(addr), .size(size),
    .drv(drv_a), .rdata(rdata_a));

  cfg_responder #(.TYPE_ID(T_TYPEX), .PHYS_ID(T_PHYSX), .EXT_EN(1'b1),
                  .EXT_ID0(T_EXT0), .EXT_ID1(T_EXT1)) dut_ext (
    .clk(clk), .rst(rst), .own_vid(vid_b), .master_vid(mvid),
    .sel(sel), .rd(rd), .req_vid(req_vid), .addr(addr), .size(size),
    .drv(drv_b), .rdata(rdata_b));

  function automatic logic [7:0] model_byte(input int off, input bit ext);
    logic [31:0] ty;
    logic [7:0]  ph;
    int o;
    ty = ext ? T_TYPEX : T_TYPE;
    ph = ext ? T_PHYSX : T_PHYS;
    o  = ext ? (off % 16) : (off % 8);
    if (o < 4)       return ty[o*8 +: 8];
    else if (o == 4) return ph;
    else if (o == 5) return mvid;
    else if (o == 6) return ~ph;
    else if (o == 7) return ~mvid;
    else if (o < 12) return T_EXT0[(o-8)*8 +: 8];
    else             return T_EXT1[(o-12)*8 +: 8];
  endfunction

  function automatic logic [31:0] model_word(input int off, input logic [1:0] sz, input bit ext);
    logic [31:0] w;
    int n;
    n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    w = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) w[k*8 +: 8] = model_byte(off + k, ext);
    return w;
  endfunction

  task automatic check(input logic [32:0] act, input logic [32:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual drv=%0b data=%08h expected drv=%0b data=%08h",
               tag, act[32], act[31:0], exp[32], exp[31:0]);
    end
  endtask

  // target: 0 none, 1 dut, 2 dut_ext
  task automatic access(input logic [7:0] v, input logic [7:0] a, input logic [1:0] sz,
                        input logic r, input int target, input string tag);
    logic [32:0] ea, eb;
    @(negedge clk);
    sel = 1'b1; rd = r; req_vid = v; addr = a; size = sz;
    @(negedge clk);
    ea = (target == 1) ? {1'b1, model_word(int'(a), sz, 1'b0)} : {1'b0, 32'hFFFF_FFFF};
    eb = (target == 2) ? {1'b1, model_word(int'(a), sz, 1'b1)} : {1'b0, 32'hFFFF_FFFF};
    check({drv_a, rdata_a}, ea, {tag, " dut"});
    check({drv_b, rdata_b}, eb, {tag, " dut_ext"});
    sel = 1'b0; rd = 1'b0;
  endtask

  task automatic test_reset;
    @(negedge clk);
    check({drv_a, rdata_a}, {1'b0, 32'hFFFF_FFFF}, "R1 reset dut");
    check({drv_b, rdata_b}, {1'b0, 32'hFFFF_FFFF}, "R1 reset dut_ext");
  endtask

  task automatic test_claim_timing;
    access(vid_a, 8'h00, 2'd2, 1'b1, 1, "R2 R5 type word");
    @(negedge clk);
    check({drv_a, rdata_a}, {1'b0, 32'hFFFF_FFFF}, "R2 R10 release after claim");
    access(vid_b, 8'h00, 2'd2, 1'b1, 2, "R5 type word ext");
  endtask

  task automatic test_ids;
    for (int o = 4; o < 8; o++) access(vid_a, 8'(o), 2'd0, 1'b1, 1, "R6 id byte");
    mvid = 8'hFF;
    access(vid_a, 8'h05, 2'd0, 1'b1, 1, "R6 root master");
    access(vid_a, 8'h07, 2'd0, 1'b1, 1, "R6 root master inverted");
    access(vid_a, 8'h04, 2'd2, 1'b1, 1, "R6 id word");
    mvid = 8'h5A;
  endtask

  task automatic test_sizes;
    access(vid_a, 8'h02, 2'd0, 1'b1, 1, "R7 byte");
    access(vid_a, 8'h04, 2'd1, 1'b1, 1, "R7 halfword");
    access(vid_a, 8'h00, 2'd3, 1'b1, 1, "R7 size3 word");
  endtask

  task automatic test_unaligned;
    access(vid_a, 8'h06, 2'd2, 1'b1, 1, "R8 wrap word");
    access(vid_a, 8'h03, 2'd1, 1'b1, 1, "R8 odd halfword");
    access(vid_b, 8'h0E, 2'd2, 1'b1, 2, "R8 wrap word ext");
  endtask

  task automatic test_alias;
    access(vid_a, 8'h0C, 2'd2, 1'b1, 1, "R9 alias 0C");
    access(vid_a, 8'h84, 2'd2, 1'b1, 1, "R9 alias high");
    access(vid_b, 8'h08, 2'd2, 1'b1, 2, "R9 ext id0");
    access(vid_b, 8'h0C, 2'd2, 1'b1, 2, "R9 ext id1");
    access(vid_b, 8'h98, 2'd2, 1'b1, 2, "R9 ext alias high");
  endtask

  task automatic test_ignored;
    access(8'h77, 8'h00, 2'd2, 1'b1, 0, "R4 vid mismatch");
    access(vid_a, 8'h00, 2'd2, 1'b0, 0, "R4 write ignored");
    @(negedge clk);
    sel = 1'b0; rd = 1'b1; req_vid = vid_a;
    @(negedge clk);
    check({drv_a, rdata_a}, {1'b0, 32'hFFFF_FFFF}, "R4 sel low");
    rd = 1'b0;
  endtask

  task automatic test_silent;
    vid_a = 8'hFF;
    access(8'hFF, 8'h00, 2'd2, 1'b1, 0, "R3 silent vid");
    vid_a = 8'h21;
    access(vid_a, 8'h01, 2'd0, 1'b1, 1, "R3 vid restored");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    test_reset();
    rst = 1'b0;
    test_claim_timing();
    test_ids();
    test_sizes();
    test_unaligned();
    test_alias();
    test_ignored();
    test_silent();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule